// File: doc/BRIEF.md
# Interlaced 4:2:2 Video Line Framer

This block turns a stream of 4:2:2 luma/chroma bytes into an interlaced standard-definition video signal on an 8-bit bus, one byte per clock. A byte counter walks each line through a fixed 1440-byte active window (720 pixels, two bytes each) followed by a programmable number of horizontal blanking bytes. A line counter walks the frame through a programmable number of lines. Programmable inclusive line ranges mark the first field, the second field and two vertical blanking intervals.

Source bytes are pulled through a ready/valid handshake, and only during the part of an active line that the source actually covers. When the source line is narrower than 720 pixels, the end of each active line is padded with black. All blanking, padding and underflow bytes are generated inside the block as black, in the same chroma/luma alternation as active video. The timing never stalls.

Top module: `sd_interlace_framer`

## Requirements
- R1: Each line has 1440 byte positions (indices 0 to 1439) followed by `hBlankLen` blanking positions. `hBlankFlag` is high exactly on the outputs of the blanking positions.
- R2: The line counter starts at 1 after reset. It counts up to `totalLines` and then returns to 1. `vBlankFlag` is high on the outputs of every line that lies in `[v1Start,v1End]` or in `[v2Start,v2End]`, bounds included.
- R3: `fieldFlag` is 1 on lines in `[f2Start,f2End]` and 0 on lines in `[f1Start,f1End]`. On any other line it keeps its previous value. It can only change on the first byte of a line.
- R4: `inReady` is high only on lines outside both vertical blanking ranges. On those lines it is high for byte indices 0 to 1439 − 2·F, where F is the fill count.
- R5: The fill count F, in pixels, is min(720 − `srcWidth`, 255) when `srcWidth` < 720, and 0 otherwise. Active positions at or after byte 1440 − 2·F carry black.
- R6: A byte accepted while `inReady` and `inValid` are both high appears on `outData` one clock later.
- R7: Active video uses the byte order Cb, Y, Cr, Y. Every generated byte is black by position: 0x80 at even byte indices (chroma) and 0x10 at odd byte indices (luma).
- R8: When `inReady` is high and `inValid` is low, the position is output as black and the counters keep running.
- R9: All outputs are registered, one clock behind the counter position. During reset, `outData` = 0x80, `hBlankFlag` = 1, `vBlankFlag` = 0 and `fieldFlag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| hBlankLen | input | HBLK_W | Horizontal blanking bytes per line |
| totalLines | input | LINE_W | Lines per frame |
| f1Start | input | LINE_W | First line of field 1 |
| f1End | input | LINE_W | Last line of field 1 |
| f2Start | input | LINE_W | First line of field 2 |
| f2End | input | LINE_W | Last line of field 2 |
| v1Start | input | LINE_W | First line of vertical blanking interval 1 |
| v1End | input | LINE_W | Last line of vertical blanking interval 1 |
| v2Start | input | LINE_W | First line of vertical blanking interval 2 |
| v2End | input | LINE_W | Last line of vertical blanking interval 2 |
| srcWidth | input | PIX_W | Source line width in pixels |
| inData | input | 8 | Source byte |
| inValid | input | 1 | Source byte valid |
| inReady | output | 1 | Block accepts a source byte |
| outData | output | 8 | Video bus byte |
| fieldFlag | output | 1 | 1 while in field 2 |
| hBlankFlag | output | 1 | Horizontal blanking position |
| vBlankFlag | output | 1 | Vertical blanking line |

## Verification
The hardest situations to reach are the 255-pixel cap on the fill count and the field flag holding its value across lines that belong to neither field range. Both only show up for particular width settings and line layouts. The bench reaches the cap with a directed 300-pixel source width. It reaches the hold with a frame whose first line lies outside both field ranges, and it runs past the frame wrap so the held value comes from field 2. Random source widths, random gaps in `inValid` and a zero-length horizontal blank cover underflow and the tightest line-end timing.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CHROMA_BLACK = 8'h80;
  localparam logic [BYTE_W-1:0] LUMA_BLACK   = 8'h10;

  typedef struct packed {
    logic takeSrc;
    logic lumaPos;
    logic hBlank;
    logic vBlank;
    logic field2;
  } strobe_t;
endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int ACTIVE_PIX = 720,
  parameter int MAX_FILL   = 255,
  parameter int LINE_W     = 10,
  parameter int HBLK_W     = 9,
  parameter int PIX_W      = $clog2(ACTIVE_PIX + 1),
  parameter int HCNT_W     = $clog2(2 * ACTIVE_PIX + (1 << HBLK_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HBLK_W-1:0] hBlankLen,
  input  logic [LINE_W-1:0] totalLines,
  input  logic [LINE_W-1:0] f1Start,
  input  logic [LINE_W-1:0] f1End,
  input  logic [LINE_W-1:0] f2Start,
  input  logic [LINE_W-1:0] f2End,
  input  logic [LINE_W-1:0] v1Start,
  input  logic [LINE_W-1:0] v1End,
  input  logic [LINE_W-1:0] v2Start,
  input  logic [LINE_W-1:0] v2End,
  input  logic [PIX_W-1:0]  srcWidth,
  output strobe_t           strobe
);
  localparam logic [HCNT_W-1:0] ACT_BYTES = HCNT_W'(2 * ACTIVE_PIX);
  localparam logic [PIX_W-1:0]  ACT_PIX   = PIX_W'(ACTIVE_PIX);
  localparam logic [PIX_W-1:0]  FILL_CAP  = PIX_W'(MAX_FILL);

  logic [HCNT_W-1:0] byteCnt;
  logic [LINE_W-1:0] lineCnt;
  logic              fieldHold;

  logic [PIX_W-1:0]  gapPix, fillPix;
  logic [HCNT_W-1:0] srcBytes;
  logic [HCNT_W:0]   lastByte;
  logic              lineDone, inV1, inV2, inF1, inF2, fieldNow;

  always_comb begin
    gapPix   = (srcWidth < ACT_PIX) ? (ACT_PIX - srcWidth) : '0;
    fillPix  = (gapPix > FILL_CAP) ? FILL_CAP : gapPix;
    srcBytes = ACT_BYTES - HCNT_W'({fillPix, 1'b0});
    lastByte = {1'b0, ACT_BYTES} + (HCNT_W+1)'(hBlankLen) - 1'b1;
    lineDone = ({1'b0, byteCnt} == lastByte);
    inV1     = (lineCnt >= v1Start) && (lineCnt <= v1End);
    inV2     = (lineCnt >= v2Start) && (lineCnt <= v2End);
    inF1     = (lineCnt >= f1Start) && (lineCnt <= f1End);
    inF2     = (lineCnt >= f2Start) && (lineCnt <= f2End);
    fieldNow = inF2 ? 1'b1 : (inF1 ? 1'b0 : fieldHold);
  end

  always_comb begin
    strobe.vBlank  = inV1 || inV2;
    strobe.hBlank  = (byteCnt >= ACT_BYTES);
    strobe.takeSrc = !strobe.vBlank && (byteCnt < srcBytes);
    strobe.lumaPos = byteCnt[0];
    strobe.field2  = fieldNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      lineCnt   <= LINE_W'(1);
      fieldHold <= 1'b0;
    end else begin
      fieldHold <= fieldNow;
      if (lineDone) begin
        byteCnt <= '0;
        lineCnt <= (lineCnt >= totalLines) ? LINE_W'(1) : lineCnt + 1'b1;
      end else begin
        byteCnt <= byteCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic [BYTE_W-1:0] outData,
  output logic              fieldFlag,
  output logic              hBlankFlag,
  output logic              vBlankFlag
);
  logic [BYTE_W-1:0] blackByte;

  always_comb blackByte = strobe.lumaPos ? LUMA_BLACK : CHROMA_BLACK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData    <= CHROMA_BLACK;
      fieldFlag  <= 1'b0;
      hBlankFlag <= 1'b1;
      vBlankFlag <= 1'b0;
    end else begin
      outData    <= (strobe.takeSrc && inValid) ? inData : blackByte;
      fieldFlag  <= strobe.field2;
      hBlankFlag <= strobe.hBlank;
      vBlankFlag <= strobe.vBlank;
    end
  end
endmodule

// File: rtl/sd_interlace_framer.sv
module sd_interlace_framer
  import framer_pkg::*;
#(
  parameter int ACTIVE_PIX = 720,
  parameter int MAX_FILL   = 255,
  parameter int LINE_W     = 10,
  parameter int HBLK_W     = 9,
  parameter int PIX_W      = $clog2(ACTIVE_PIX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HBLK_W-1:0] hBlankLen,
  input  logic [LINE_W-1:0] totalLines,
  input  logic [LINE_W-1:0] f1Start,
  input  logic [LINE_W-1:0] f1End,
  input  logic [LINE_W-1:0] f2Start,
  input  logic [LINE_W-1:0] f2End,
  input  logic [LINE_W-1:0] v1Start,
  input  logic [LINE_W-1:0] v1End,
  input  logic [LINE_W-1:0] v2Start,
  input  logic [LINE_W-1:0] v2End,
  input  logic [PIX_W-1:0]  srcWidth,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [7:0]        outData,
  output logic              fieldFlag,
  output logic              hBlankFlag,
  output logic              vBlankFlag
);
  strobe_t strobe;

  framer_ctrl #(
    .ACTIVE_PIX(ACTIVE_PIX), .MAX_FILL(MAX_FILL), .LINE_W(LINE_W),
    .HBLK_W(HBLK_W), .PIX_W(PIX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .hBlankLen(hBlankLen), .totalLines(totalLines),
    .f1Start(f1Start), .f1End(f1End), .f2Start(f2Start), .f2End(f2End),
    .v1Start(v1Start), .v1End(v1End), .v2Start(v2Start), .v2End(v2End),
    .srcWidth(srcWidth), .strobe(strobe)
  );

  framer_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .inValid(inValid), .outData(outData), .fieldFlag(fieldFlag),
    .hBlankFlag(hBlankFlag), .vBlankFlag(vBlankFlag)
  );

  assign inReady = strobe.takeSrc;
endmodule

// File: rtl/framer_checker.sv
module framer_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] inData,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       fieldFlag,
  input logic       hBlankFlag,
  input logic       vBlankFlag
);
  assert_ready_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> (!hBlankFlag && !vBlankFlag));

  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |=> (outData == $past(inData)));

  assert_blank_black_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hBlankFlag || vBlankFlag) |-> (outData == 8'h10 || outData == 8'h80));

  assert_field_line_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldFlag) |-> !hBlankFlag);
endmodule

bind sd_interlace_framer framer_checker chk_i (
  .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
  .inReady(inReady), .outData(outData), .fieldFlag(fieldFlag),
  .hBlankFlag(hBlankFlag), .vBlankFlag(vBlankFlag)
);

// File: tb/sd_interlace_framer_tb.sv
`timescale 1ns/1ps
module sd_interlace_framer_tb_top;
  localparam int LINE_W = 10;
  localparam int HBLK_W = 9;
  localparam int PIX_W  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [HBLK_W-1:0] hBlankLen = '0;
  logic [LINE_W-1:0] totalLines = '0, f1Start = '0, f1End = '0, f2Start = '0, f2End = '0;
  logic [LINE_W-1:0] v1Start = '0, v1End = '0, v2Start = '0, v2End = '0;
  logic [PIX_W-1:0]  srcWidth = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady, fieldFlag, hBlankFlag, vBlankFlag;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sd_interlace_framer dut_i (
    .clk(clk), .rstN(rstN), .hBlankLen(hBlankLen), .totalLines(totalLines),
    .f1Start(f1Start), .f1End(f1End), .f2Start(f2Start), .f2End(f2End),
    .v1Start(v1Start), .v1End(v1End), .v2Start(v2Start), .v2End(v2End),
    .srcWidth(srcWidth), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .fieldFlag(fieldFlag), .hBlankFlag(hBlankFlag),
    .vBlankFlag(vBlankFlag)
  );

  function automatic int fillOf(int w);
    int g = (w < 720) ? 720 - w : 0;
    return (g > 255) ? 255 : g;
  endfunction

  function automatic bit inRange(int l, int s, int e);
    return (l >= s) && (l <= e);
  endfunction

  function automatic logic [7:0] blackAt(int b);
    return b[0] ? 8'h10 : 8'h80;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one phase: reset, then run nLines lines with a bench model of the frame
  task automatic runPhase(int width, int hbl, int validPct, int nLines);
    int mLine = 1, mByte = 0, mField = 0, done = 0;
    int eData = 8'h80, eField = 0, eH = 1, eV = 0;
    string dTag = "R9";
    string fTag = "R9";
    srcWidth = PIX_W'(width);
    hBlankLen = HBLK_W'(hbl);
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    while (done < nLines) begin
      bit vb, hb, rdy, v;
      logic [7:0] d;
      check(dTag, outData, eData);
      check(fTag == "R9" ? "R9" : "R3", fieldFlag, eField);
      check(fTag == "R9" ? "R9" : "R1", hBlankFlag, eH);
      check(fTag == "R9" ? "R9" : "R2", vBlankFlag, eV);
      fTag = "run";
      vb = inRange(mLine, 1, 1) || inRange(mLine, 5, 5);
      if (inRange(mLine, 6, 8)) mField = 1;
      else if (inRange(mLine, 2, 4)) mField = 0;
      hb = (mByte >= 1440);
      rdy = !vb && (mByte < 1440 - 2 * fillOf(width));
      check("R4", inReady, rdy);
      v = (($urandom % 100) < validPct);
      d = 8'($urandom);
      inValid = v;
      inData = d;
      if (rdy && v) begin eData = d; dTag = "R6"; end
      else if (rdy) begin eData = blackAt(mByte); dTag = "R8"; end
      else if (!vb && !hb) begin eData = blackAt(mByte); dTag = "R5"; end
      else begin eData = blackAt(mByte); dTag = "R7"; end
      eField = mField; eH = hb; eV = vb;
      if (mByte == 1440 + hbl - 1) begin
        mByte = 0;
        mLine = (mLine >= 8) ? 1 : mLine + 1;
        done++;
      end else mByte++;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    totalLines = 10'd8;
    v1Start = 10'd1; v1End = 10'd1;
    f1Start = 10'd2; f1End = 10'd4;
    v2Start = 10'd5; v2End = 10'd5;
    f2Start = 10'd6; f2End = 10'd8;
    runPhase(720, 8 + ($urandom % 33), 90, 11);   // full width, R1 R2 R3 R6
    runPhase(700, 8 + ($urandom % 33), 85, 10);   // 20-pixel fill, R5
    runPhase(300, 12, 95, 9);                     // fill capped at 255, R5
    runPhase(466 + ($urandom % 254), 0, 50, 10);  // no hblank, heavy underflow R8
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule